// File: doc/BRIEF.md
# Measured-Interval 1024x Pulse Stretcher

This block is a retriggerable one-shot. Its output pulse lasts 1024 times a reference interval. The interval is set by an external timing network: the block drives a discharge control, and an external comparator reports, as a single digital input, when the network's threshold has been reached. The block times this interval against its own clock over a short run of measurement cycles. When the measurements settle, or when the measurement budget runs out, the last count is held.

The held count is then replayed digitally, one replay cycle after another, until measurement cycles and replay cycles together reach 1024. The time spent measuring is therefore part of the pulse rather than added on top of it. While replaying, the block drops its comparator-enable output so that the analog side can be powered down. A new trigger edge at any time restarts the whole sequence.

Top module: `pstr_top`

## Requirements
- R1: The pulse is made of exactly 1024 interval cycles: while `pulse_o` is high, the number of measurement cycles plus the number of replay cycles totals 1024. Each replay cycle lasts `saved` clocks.
- R2: No more than 12 measurement cycles are run. After the 12th, replay starts using the 12th count.
- R3: Measurement stops as soon as two consecutive counts differ by at most 1, and the later count is kept. A difference of 2 or more starts another measurement cycle.
- R4: `cmp_en_o` is high during every measurement cycle and low for the whole replay phase.
- R5: Each measurement cycle starts with `discharge_o` high for exactly 2 clocks. A high `cmp_i` during those clocks has no effect on the count.
- R6: After discharge, the count is the number of clocks in which `cmp_i` was sampled low before it was first sampled high. A measurement cycle whose count is m lasts 2+m+1 clocks.
- R7: A rising edge on `trig_i` restarts the sequence from cycle 0 on the next clock, including while a pulse is active, and `pulse_o` stays high through the restart. A trigger held high does not fire again.
- R8: A kept count of 0 is replayed as 1 clock per cycle.
- R9: The count saturates at 65535. If `cmp_i` never rises, measurement ends after one cycle of 2+65536 clocks, and replay starts.
- R10: After the last cycle, `pulse_o` falls and stays low. The block is then ready, and a later trigger edge starts a new full pulse.
- R11: After reset, `pulse_o`, `discharge_o` and `cmp_en_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trig_i | input | 1 | Trigger; a rising edge starts or restarts a pulse |
| cmp_i | input | 1 | Comparator output, high once the threshold is reached |
| discharge_o | output | 1 | Discharge control for the external timing network |
| cmp_en_o | output | 1 | Comparator enable, high during measurement only |
| pulse_o | output | 1 | Stretched one-shot output |

## Verification
A modelled comparator rises a set number of clocks after each discharge, and that number can be different for every measurement cycle. The bench uses this to drive several count sequences. A sequence that converges within one tick is separated from one that jumps by two. A sequence that never settles shows the 12-cycle cap, and all-zero counts show the one-clock floor. For each run, the bench compares the pulse width, the number of comparator-enable clocks and the number of discharge clocks with a length model built from the requirements, so an off-by-one in the cycle total or in the handover to replay shows up. Three further scenarios are run: a comparator that never fires (saturation), a retrigger in the middle of replay, and a comparator held high during discharge.

// File: rtl/pstr_pkg.sv
// Shared types for the pulse stretcher.
// Assumes: nothing beyond IEEE 1800-2017.
package pstr_pkg;
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_DRAIN  = 3'd1,
        ST_WATCH  = 3'd2,
        ST_REPLAY = 3'd3,
        ST_GAP    = 3'd4
    } pstr_state_e;
endpackage

// File: rtl/pstr_tick_timer.sv
// Saturating tick counter, used both to measure an interval and to replay it.
// Assumes: clr has priority over inc; the count stays at all-ones once there.
module pstr_tick_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt,
    output logic         sat
);
    assign sat = &cnt;

    // Clear, or count up until saturation.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (clr)        cnt <= '0;
        else if (inc && !sat) cnt <= cnt + 1'b1;
    end

    // R9: a saturated count holds until it is cleared.
    p_sat_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sat && !clr) |=> sat);
endmodule

// File: rtl/pstr_cycle_ctr.sv
// Counts interval cycles completed in the current pulse (measured plus replayed).
// Assumes: the controller stops incrementing when TOTAL is reached.
module pstr_cycle_ctr #(
    parameter int TOTAL = 1024,
    parameter int CW    = $clog2(TOTAL + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          inc,
    output logic [CW-1:0] cnt
);
    // Clear on restart, step once per finished cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)   cnt <= '0;
        else if (clr) cnt <= '0;
        else if (inc) cnt <= cnt + 1'b1;
    end

    // R1: the total never runs past TOTAL cycles.
    p_cyc_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(TOTAL));
endmodule

// File: rtl/pstr_fsm.sv
// Sequencer: discharge, watch the comparator, decide whether measurement has
// settled, then replay the kept count until the cycle total is reached.
// Assumes: rise is a one-clock trigger strobe; timer and cycle counter are
// the sibling modules driven from the strobes produced here.
module pstr_fsm
    import pstr_pkg::*;
#(
    parameter int TOTAL      = 1024,
    parameter int MAX_MEAS   = 12,
    parameter int DRAIN_CLKS = 2,
    parameter int W          = 16,
    parameter int CW         = $clog2(TOTAL + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rise,
    input  logic          cmp_i,
    input  logic [W-1:0]  tmr_cnt,
    input  logic          tmr_sat,
    input  logic [CW-1:0] cyc_cnt,
    output pstr_state_e   state,
    output logic          tmr_clr,
    output logic          tmr_inc,
    output logic          cyc_clr,
    output logic          cyc_inc
);
    localparam int DW = $clog2(DRAIN_CLKS + 1);
    localparam logic [CW-1:0] LAST_MEAS = CW'(MAX_MEAS - 1);
    localparam logic [CW-1:0] LAST_CYC  = CW'(TOTAL - 1);
    localparam logic [DW-1:0] DRAIN_END = DW'(DRAIN_CLKS - 1);

    pstr_state_e   nxt;
    logic [DW-1:0] dcnt;
    logic [W-1:0]  prev, saved, diff;
    logic          have_prev, meas_end, meas_last, close, rep_end;

    // Distance between this count and the previous one.
    always_comb diff = (tmr_cnt >= prev) ? (tmr_cnt - prev) : (prev - tmr_cnt);

    // Decisions at the end of a measurement or replay cycle.
    always_comb begin
        meas_end  = (state == ST_WATCH) && (cmp_i || tmr_sat);
        close     = have_prev && (diff <= W'(1));
        meas_last = close || tmr_sat || (cyc_cnt == LAST_MEAS);
        rep_end   = (state == ST_REPLAY) && (tmr_cnt == saved - 1'b1);
    end

    // Next state and counter strobes.
    always_comb begin
        nxt     = state;
        tmr_clr = 1'b0;
        tmr_inc = 1'b0;
        cyc_clr = 1'b0;
        cyc_inc = 1'b0;
        if (rise) begin
            nxt     = ST_DRAIN;
            tmr_clr = 1'b1;
            cyc_clr = 1'b1;
        end else begin
            case (state)
                ST_DRAIN: begin
                    tmr_clr = 1'b1;
                    if (dcnt == DRAIN_END) nxt = ST_WATCH;
                end
                ST_WATCH: begin
                    if (meas_end) begin
                        tmr_clr = 1'b1;
                        cyc_inc = 1'b1;
                        nxt     = meas_last ? ST_REPLAY : ST_DRAIN;
                    end else begin
                        tmr_inc = 1'b1;
                    end
                end
                ST_REPLAY: begin
                    if (rep_end) begin
                        tmr_clr = 1'b1;
                        cyc_inc = 1'b1;
                        if (cyc_cnt == LAST_CYC) nxt = ST_GAP;
                    end else begin
                        tmr_inc = 1'b1;
                    end
                end
                ST_GAP:  nxt = ST_IDLE;
                default: nxt = state;
            endcase
        end
    end

    // State, discharge length counter, previous and kept counts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            dcnt      <= '0;
            prev      <= '0;
            saved     <= W'(1);
            have_prev <= 1'b0;
        end else begin
            state <= nxt;
            dcnt  <= (state == ST_DRAIN && !rise) ? dcnt + 1'b1 : '0;
            if (rise) begin
                have_prev <= 1'b0;
            end else if (meas_end) begin
                prev      <= tmr_cnt;
                have_prev <= 1'b1;
                if (meas_last) saved <= (tmr_cnt == '0) ? W'(1) : tmr_cnt;
            end
        end
    end

    // R7: a trigger edge restarts at cycle 0 with a discharge.
    p_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> (state == ST_DRAIN) && (cyc_cnt == '0));
    // R2: measurement never runs beyond MAX_MEAS cycles.
    p_meas_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WATCH) |-> (cyc_cnt < CW'(MAX_MEAS)));
    // R8: the replayed length is never zero.
    p_saved_nonzero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_REPLAY) |-> (saved != '0));
    // R1: the end gap is reached only after TOTAL cycles.
    p_total_done_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_GAP) |-> (cyc_cnt == CW'(TOTAL)));
    // R10: the end gap lasts a single clock.
    p_gap_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_GAP) |=> (state != ST_GAP));
endmodule

// File: rtl/pstr_top.sv
// Retriggerable 1024x pulse stretcher: measures an external interval in a few
// cycles, then replays the kept count digitally up to 1024 total cycles.
// Assumes: cmp_i is already synchronous to clk; trig_i is sampled once a clock.
module pstr_top
    import pstr_pkg::*;
#(
    parameter int TOTAL      = 1024,
    parameter int MAX_MEAS   = 12,
    parameter int DRAIN_CLKS = 2,
    parameter int W          = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_i,
    input  logic cmp_i,
    output logic discharge_o,
    output logic cmp_en_o,
    output logic pulse_o
);
    localparam int CW = $clog2(TOTAL + 1);

    pstr_state_e   state;
    logic          trig_q, rise;
    logic          tmr_clr, tmr_inc, tmr_sat, cyc_clr, cyc_inc;
    logic [W-1:0]  tmr_cnt;
    logic [CW-1:0] cyc_cnt;

    // Remember last trigger level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) trig_q <= 1'b0;
        else        trig_q <= trig_i;
    end
    assign rise = trig_i & ~trig_q;

    pstr_fsm #(.TOTAL(TOTAL), .MAX_MEAS(MAX_MEAS), .DRAIN_CLKS(DRAIN_CLKS),
               .W(W), .CW(CW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .rise(rise), .cmp_i(cmp_i),
        .tmr_cnt(tmr_cnt), .tmr_sat(tmr_sat), .cyc_cnt(cyc_cnt),
        .state(state), .tmr_clr(tmr_clr), .tmr_inc(tmr_inc),
        .cyc_clr(cyc_clr), .cyc_inc(cyc_inc));

    pstr_tick_timer #(.W(W)) u_tmr (
        .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .inc(tmr_inc),
        .cnt(tmr_cnt), .sat(tmr_sat));

    pstr_cycle_ctr #(.TOTAL(TOTAL), .CW(CW)) u_cyc (
        .clk(clk), .rst_n(rst_n), .clr(cyc_clr), .inc(cyc_inc), .cnt(cyc_cnt));

    assign discharge_o = (state == ST_DRAIN);
    assign cmp_en_o    = (state == ST_DRAIN) || (state == ST_WATCH);
    assign pulse_o     = (state == ST_DRAIN) || (state == ST_WATCH) ||
                         (state == ST_REPLAY);

    // R4: the comparator is never enabled while replaying past measurement.
    p_cmp_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_o && !cmp_en_o) |=> (!cmp_en_o || $past(rise) || !pulse_o || discharge_o));
endmodule

// File: tb/pstr_top_tb.sv
module pstr_top_tb;
    logic clk = 1'b0, rst_n = 1'b0, trig_i = 1'b0, cmp_i = 1'b0;
    logic discharge_o, cmp_en_o, pulse_o;
    int n_run = 0, n_fail = 0;
    int klist[16];
    int nk = 1, kstart = 0, dis_rises = 0, mcount = 0;
    bit glitch = 1'b0, cmp_off = 1'b0, dis_prev = 1'b0, finished = 1'b0;

    always #4 clk = ~clk;

    pstr_top u_dut (.clk(clk), .rst_n(rst_n), .trig_i(trig_i), .cmp_i(cmp_i),
        .discharge_o(discharge_o), .cmp_en_o(cmp_en_o), .pulse_o(pulse_o));

    // Comparator model: rises klist[i] clocks into the watch of cycle i.
    always @(negedge clk) begin
        int idx;
        if (discharge_o) begin
            mcount = 0;
            if (!dis_prev) dis_rises = dis_rises + 1;
        end else begin
            mcount = mcount + 1;
        end
        dis_prev = discharge_o;
        idx = dis_rises - kstart - 1;
        if (idx < 0) idx = 0;
        if (idx > nk - 1) idx = nk - 1;
        if (discharge_o)  cmp_i = glitch;
        else if (cmp_off) cmp_i = 1'b0;
        else              cmp_i = (mcount > klist[idx]);
    end

    task automatic check(string req, int act, int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Length model from the requirements.
    task automatic model(output int n, output int len, output int meas);
        int prev = 0, m = 0;
        meas = 0;
        n = 0;
        for (int i = 0; i < 12; i++) begin
            m = klist[(i < nk) ? i : nk - 1];
            meas += 3 + m;
            n = i + 1;
            if (i > 0 && (m - prev <= 1) && (prev - m <= 1)) break;
            prev = m;
        end
        len = meas + (1024 - n) * ((m == 0) ? 1 : m);
    endtask

    // Trigger one pulse and check width, comparator-enable and discharge clocks.
    task automatic run_pulse(string tag);
        int n, len, meas, cnt = 0, cen = 0, dc = 0;
        model(n, len, meas);
        kstart = dis_rises;
        @(negedge clk) trig_i = 1'b1;
        forever begin
            @(negedge clk);
            if (!pulse_o) break;
            cnt++;
            if (cmp_en_o) cen++;
            if (discharge_o) dc++;
        end
        check({tag, " R1 pulse width"}, cnt, len);
        check({tag, " R4 cmp_en clocks"}, cen, meas);
        check({tag, " R5 discharge clocks"}, dc, 2 * n);
        repeat (20) @(negedge clk) if (pulse_o) cnt = -1;
        check({tag, " R7/R10 held trigger stays low"}, cnt, len);
        trig_i = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset();
        check("R11 reset outputs", {pulse_o, discharge_o, cmp_en_o}, 0);
    endtask

    task automatic t_converge();   // R3 R6: steps 5,6,1 then within 1
        nk = 4; klist[0] = 4; klist[1] = 9; klist[2] = 15; klist[3] = 16;
        run_pulse("converge R3 R6");
    endtask

    task automatic t_equal_glitch(); // R5: cmp high in discharge ignored
        nk = 2; klist[0] = 7; klist[1] = 7; glitch = 1'b1;
        run_pulse("equal R5");
        glitch = 1'b0;
    endtask

    task automatic t_diff2();      // R3: diff of 2 keeps measuring
        nk = 3; klist[0] = 7; klist[1] = 9; klist[2] = 10;
        run_pulse("diff2 R3");
    endtask

    task automatic t_cap();        // R2: never settles, 12 cycles
        nk = 12;
        for (int i = 0; i < 12; i++) klist[i] = (i % 2 == 0) ? 5 : 8;
        run_pulse("cap R2");
    endtask

    task automatic t_zero();       // R8: zero count replays as 1
        nk = 2; klist[0] = 0; klist[1] = 0;
        run_pulse("zero R8");
    endtask

    task automatic t_retrig();     // R7: restart during replay
        int cnt = 0, dc = 0, drop = 0;
        nk = 2; klist[0] = 3; klist[1] = 3; kstart = dis_rises;
        @(negedge clk) trig_i = 1'b1;
        repeat (300) @(negedge clk);
        check("R4 cmp_en low in replay", cmp_en_o, 0);
        @(negedge clk) trig_i = 1'b0;
        if (!pulse_o) drop = 1;
        klist[0] = 5; klist[1] = 5; kstart = dis_rises;
        @(negedge clk) trig_i = 1'b1;
        if (!pulse_o) drop = 1;
        forever begin
            @(negedge clk);
            if (!pulse_o) break;
            cnt++;
            if (discharge_o) dc++;
        end
        check("R7 pulse stayed high at restart", drop, 0);
        check("R7 restarted width", cnt, 8 + 8 + 1022 * 5);
        check("R7 restarted discharge clocks", dc, 4);
        trig_i = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_sat();        // R9: comparator never fires
        int cen = 0;
        cmp_off = 1'b1; kstart = dis_rises;
        @(negedge clk) trig_i = 1'b1;
        forever begin
            @(negedge clk);
            if (!cmp_en_o) break;
            cen++;
        end
        check("R9 saturated measurement clocks", cen, 2 + 65536);
        check("R9 pulse continues into replay", pulse_o, 1);
        repeat (100) @(negedge clk);
        check("R9 no further discharge", discharge_o, 0);
        cmp_off = 1'b0;
        trig_i = 1'b0;
        repeat (2) @(negedge clk);
        nk = 2; klist[0] = 3; klist[1] = 3;
        run_pulse("after-sat R7 R10");
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_converge();
        t_equal_glitch();
        t_diff2();
        t_cap();
        t_zero();
        t_retrig();
        t_sat();
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (195000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule